// File: doc/BRIEF.md
# Synchronous SRAM Data Path with Dual-Cycle Deselect

This block is the data side of a synchronous static RAM. On each rising clock edge it samples a chip select, two write controls, a per-byte select vector, an address and write data. A selected cycle with a write control asserted updates a small internal register file. The update is either a global write of every byte or a masked write of chosen bytes. A selected cycle with neither write control asserted is a read.

Read data reaches the output in one of two ways, chosen by a mode input that may change at runtime. In flow-through mode it comes straight from the array. In pipelined mode it passes through an output register first. The bus drive enable travels through the same stages as the read data. A deselect, an idle cycle or a write therefore turns the drivers off with the same latency that a read turns them on. In pipelined mode this keeps the bus driven for one full extra cycle after a deselect. An active-low output enable and an active-high sleep input act on the drive enable without a clock. While sleep is high, sampled commands are also dropped and the stored data is kept.

Top module: `sram_dp`

## Requirements
- R1: While reset is asserted and after its release with no command issued, `drive_o` is 0.
- R2: A selected cycle (`ce_ni`=0, `sleep_i`=0) with `gw_ni`=0 writes all bytes of `wdata_i` to `addr_i`, whatever `bwe_ni` and `bsel_ni` are.
- R3: A selected cycle with `gw_ni`=1 and `bwe_ni`=0 writes only byte i (bits [8i+7:8i] at default width) for each i with `bsel_ni[i]`=0. The other bytes keep their contents.
- R4: A cycle with `ce_ni`=1 writes nothing, whatever the write controls are.
- R5: With `pipe_i`=0, a read sampled at edge k presents the stored word on `rdata_o` with `drive_o`=1 from just after edge k until the next edge.
- R6: With `pipe_i`=1, a read sampled at edge k presents the stored word on `rdata_o` with `drive_o`=1 from just after edge k+1.
- R7: With `pipe_i`=1, a non-read cycle (deselect, idle or write) sampled at edge k leaves `drive_o` as it was until edge k+1 and turns it off just after edge k+1.
- R8: `oe_ni`=1 forces `drive_o` to 0 with no clock edge needed. Returning `oe_ni` to 0 restores the drive state of the pipeline.
- R9: `sleep_i`=1 forces `drive_o` to 0 with no clock edge needed. Commands sampled while it is high do not write, and stored data is kept across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low (pipeline state only) |
| ce_ni | input | 1 | Chip select, active low, sampled |
| gw_ni | input | 1 | Global write of all bytes, active low |
| bwe_ni | input | 1 | Byte-masked write enable, active low |
| bsel_ni | input | NB | Per-byte select for masked writes, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | NB*BW | Write data |
| pipe_i | input | 1 | Read timing: 0 flow-through, 1 pipelined |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| rdata_o | output | NB*BW | Read data |
| drive_o | output | 1 | Data bus drive enable (1 = driven) |

## Verification
The assertions sample the drive enable on the falling edge. They assume `pipe_i`, `oe_ni` and `sleep_i` are steady from there through the next rising edge, so that the mode seen by the check is the mode the output mux applies. The bench changes every input one nanosecond after a rising edge and reads outputs at that same point. The drive-latency properties also assume that a read is not aimed at a word written in the same or the following cycle. The stimulus keeps every read-after-write at least two cycles apart.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sram_dp_ctrl.sv
module sram_dp_ctrl
  import sram_dp_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          ce_ni,
  input  logic          sleep_i,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bsel_ni,
  output cmd_e          cmd_o,
  output logic [NB-1:0] be_o
);
  always_comb begin
    cmd_o = CMD_IDLE;
    be_o  = '0;
    if (!ce_ni && !sleep_i) begin
      if (!gw_ni) begin
        // global write wins over the byte path
        cmd_o = CMD_WRITE;
        be_o  = '1;
      end else if (!bwe_ni) begin
        cmd_o = CMD_WRITE;
        be_o  = ~bsel_ni;
      end else begin
        cmd_o = CMD_READ;
      end
    end
  end
endmodule

// File: rtl/sram_dp_array.sv
module sram_dp_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (be_i[b]) lane_q[waddr_i] <= wdata_i[b*BW +: BW];
    end
    assign rdata_o[b*BW +: BW] = lane_q[raddr_i];
  end
endmodule

// File: rtl/sram_dp_outpipe.sv
module sram_dp_outpipe #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] arr_i,
  input  logic          pipe_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic          rd_q, rd_qq;
  logic [DW-1:0] data_q;
  logic          en;

  // drive enable rides the same stages as data: deselect costs equal latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      rd_qq  <= 1'b0;
      data_q <= '0;
    end else begin
      rd_q  <= rd_i;
      rd_qq <= rd_q;
      if (rd_q) data_q <= arr_i;
    end
  end

  assign en      = pipe_i ? rd_qq : rd_q;
  assign rdata_o = pipe_i ? data_q : arr_i;
  assign drive_o = en & ~oe_ni & ~sleep_i;
endmodule

// File: rtl/sram_dp.sv
module sram_dp
  import sram_dp_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bsel_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pipe_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  cmd_e          cmd;
  logic [NB-1:0] be_w;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] arr_data;

  sram_dp_ctrl #(.NB(NB)) u_ctrl (
    .ce_ni   (ce_ni),
    .sleep_i (sleep_i),
    .gw_ni   (gw_ni),
    .bwe_ni  (bwe_ni),
    .bsel_ni (bsel_ni),
    .cmd_o   (cmd),
    .be_o    (be_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (cmd == CMD_READ)   addr_q <= addr_i;
  end

  sram_dp_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk_i   (clk_i),
    .be_i    (be_w),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (arr_data)
  );

  sram_dp_outpipe #(.DW(DW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (cmd == CMD_READ),
    .arr_i   (arr_data),
    .pipe_i  (pipe_i),
    .oe_ni   (oe_ni),
    .sleep_i (sleep_i),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/sram_dp_chk.sv
module sram_dp_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          gw_ni,
  input logic          bwe_ni,
  input logic [NB-1:0] bsel_ni,
  input logic          pipe_i,
  input logic          oe_ni,
  input logic          sleep_i,
  input logic          drive_o,
  input logic [NB-1:0] be_w
);
  logic sel, rd_now, rd1_q, rd2_q;
  assign sel    = !ce_ni && !sleep_i;
  assign rd_now = sel && gw_ni && bwe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd1_q <= 1'b0;
      rd2_q <= 1'b0;
    end else begin
      rd1_q <= rd_now;
      rd2_q <= rd1_q;
    end
  end

  // R1
  always_comb begin
    if (!rst_ni) reset_quiet_chk: assert (!drive_o);
  end

  // R8
  oe_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  // R9
  sleep_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o);

  // R2
  gw_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !gw_ni) |-> (be_w == {NB{1'b1}}));

  // R3
  bw_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && gw_ni && !bwe_ni) |-> (be_w == ~bsel_ni));

  // R4
  desel_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (be_w == '0));

  // R9
  sleep_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (be_w == '0));

  // R5
  flow_drive_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!pipe_i && !oe_ni && !sleep_i) |-> (drive_o == rd1_q));

  // R6
  pipe_drive_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (pipe_i && !oe_ni && !sleep_i && rd2_q) |-> drive_o);

  // R7
  dcd_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (pipe_i && !rd2_q) |-> !drive_o);
endmodule

bind sram_dp sram_dp_chk #(.NB(NB)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_ni   (ce_ni),
  .gw_ni   (gw_ni),
  .bwe_ni  (bwe_ni),
  .bsel_ni (bsel_ni),
  .pipe_i  (pipe_i),
  .oe_ni   (oe_ni),
  .sleep_i (sleep_i),
  .drive_o (drive_o),
  .be_w    (be_w)
);

// File: tb/sram_dp_test.sv
`timescale 1ns/1ps
module sram_dp_test;
  localparam int AW = 4, NB = 4, BW = 8, DW = NB * BW;

  logic          clk_i = 0, rst_ni = 0;
  logic          ce_ni = 1, gw_ni = 1, bwe_ni = 1, pipe_i = 0, oe_ni = 0, sleep_i = 0;
  logic [NB-1:0] bsel_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int errors = 0, checks = 0;
  logic [DW-1:0] model [1<<AW];

  sram_dp uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    ce_ni = 1; gw_ni = 1; bwe_ni = 1; bsel_ni = '1;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic g, logic bw,
                          logic [NB-1:0] bs, logic ce);
    ce_ni = ce; gw_ni = g; bwe_ni = bw; bsel_ni = bs; addr_i = a; wdata_i = d;
    if (!ce && !sleep_i) begin
      for (int b = 0; b < NB; b++)
        if (!g || (!bw && !bs[b])) model[a][b*BW +: BW] = d[b*BW +: BW];
    end
    tick();
    idle();
  endtask

  // flow-through read: data valid just after the sampling edge
  task automatic flow_read(string req, logic [AW-1:0] a);
    pipe_i = 0; ce_ni = 0; gw_ni = 1; bwe_ni = 1; addr_i = a;
    tick();
    idle();
    chk(req, {31'd0, drive_o}, 1);
    chk(req, rdata_o, model[a]);
    tick();
  endtask

  task automatic t_reset();
    #1 chk("R1", {31'd0, drive_o}, 0);
    rst_ni = 1;
    tick(); tick();
    chk("R1", {31'd0, drive_o}, 0);
  endtask

  task automatic t_global();
    do_write(4'd1, 32'h1111_1111, 0, 1, '1, 0);
    do_write(4'd1, 32'hA1B2_C3D4, 0, 0, 4'b1111, 0); // byte path says none
    tick();
    flow_read("R2", 4'd1);
  endtask

  task automatic t_bytes();
    do_write(4'd2, 32'h0000_0000, 0, 1, '1, 0);
    do_write(4'd2, 32'hDEAD_BEEF, 1, 0, 4'b1010, 0); // bytes 0 and 2
    tick();
    flow_read("R3", 4'd2);
    do_write(4'd2, 32'h5566_7788, 1, 0, 4'b0111, 0); // byte 3 only
    tick();
    flow_read("R3", 4'd2);
    chk("R3", model[2], 32'h55AD_00EF);
  endtask

  task automatic t_desel();
    do_write(4'd3, 32'h3333_3333, 0, 1, '1, 0);
    do_write(4'd3, 32'hFFFF_FFFF, 0, 0, 4'b0000, 1); // ce high
    tick();
    flow_read("R4", 4'd3);
  endtask

  task automatic t_flow_end();
    pipe_i = 0; ce_ni = 0; addr_i = 4'd1;
    tick();
    ce_ni = 1; // deselect
    chk("R5", {31'd0, drive_o}, 1);
    tick();
    chk("R5", {31'd0, drive_o}, 0);
  endtask

  task automatic t_pipe();
    pipe_i = 1; ce_ni = 0; addr_i = 4'd2;
    tick();                       // edge k: read sampled
    addr_i = 4'd1;                // edge k+1: second read
    chk("R6", {31'd0, drive_o}, 0);
    tick();
    ce_ni = 1;                    // edge k+2: deselect
    chk("R6", {31'd0, drive_o}, 1);
    chk("R6", rdata_o, model[2]);
    tick();
    chk("R6", {31'd0, drive_o}, 1);
    chk("R6", rdata_o, model[1]);
    tick();                       // deselect held a full cycle, off now
    chk("R7", {31'd0, drive_o}, 0);
    // a write also releases the bus after two edges
    ce_ni = 0; addr_i = 4'd3;
    tick();
    gw_ni = 0; addr_i = 4'd9; wdata_i = 32'h9999_0000; model[9] = wdata_i;
    tick();
    idle();
    chk("R7", {31'd0, drive_o}, 1);
    chk("R7", rdata_o, model[3]);
    tick();
    chk("R7", {31'd0, drive_o}, 0);
    pipe_i = 0;
  endtask

  task automatic t_oe();
    pipe_i = 1; ce_ni = 0; addr_i = 4'd1;
    tick(); tick();               // second read keeps drive high next cycle
    idle();
    chk("R8", {31'd0, drive_o}, 1);
    oe_ni = 1; #0.5;
    chk("R8", {31'd0, drive_o}, 0);
    oe_ni = 0; #0.5;
    chk("R8", {31'd0, drive_o}, 1);
    tick(); tick();
    pipe_i = 0;
  endtask

  task automatic t_sleep();
    do_write(4'd5, 32'h0BAD_F00D, 0, 1, '1, 0);
    tick();
    pipe_i = 0; ce_ni = 0; addr_i = 4'd5;
    tick();
    chk("R9", {31'd0, drive_o}, 1);
    sleep_i = 1; #0.5;
    chk("R9", {31'd0, drive_o}, 0);
    do_write(4'd5, 32'h1234_5678, 0, 1, '1, 0); // ignored in sleep
    tick();
    sleep_i = 0;
    tick();
    flow_read("R9", 4'd5);
    chk("R9", model[5], 32'h0BAD_F00D);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_global();
        t_bytes();
        t_desel();
        t_flow_end();
        t_pipe();
        t_oe();
        t_sleep();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule